// File: doc/BRIEF.md
# Watchdog Timer with Interrupt, Reset and Guarded Settings

This block is a watchdog timer. It counts pulses of a slow clock enable (`osc_tick`) that stands for a separate low-speed oscillator. A timed-out count raises an interrupt request, emits a system reset pulse one clock long, or does both in turn. Firmware clears the count with a `kick` pulse. It sets the block up through a write strobe with an 8-bit word, and reads the live settings back on `cfg_rdata`.

The time-out period is `BASE << code` ticks. The code is a 4-bit select, and codes above `MAX_SEL` act as `MAX_SEL`. With the defaults the shortest period is 2048 ticks, which is about 16 ms on a 128 kHz oscillator. Once reset generation is on, it can only be turned off through a guarded sequence, and the same holds for a change of period. Firmware first writes an unlock word that carries both the unlock bit and the reset-enable bit. A settings write is then accepted only within the next `WIN` clocks. In the combined mode the first time-out raises the interrupt and the hardware drops the interrupt enable. If firmware does not service it, the next time-out resets the system.

Write word and read word layout: bits [3:0] hold the period code. Bit 4 is the reset enable and bit 5 the interrupt enable. On a write, bit 6 is unlock and bit 7 clears the interrupt flag. On a read, bit 6 shows the window as open and bit 7 is the interrupt flag.

Top module: `watchdog_ctrl`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00 (code 0, both enables off, window closed, flag clear), and `irq` and `rst_pulse` are low.
- R2: After a kick, a time-out occurs on exactly the `BASE << code`-th `osc_tick`. Its effect shows at the clock edge that follows that tick. Clocks without `osc_tick` do not advance the count.
- R3: Period codes above `MAX_SEL` give the same period as `MAX_SEL`, and the raw code reads back unchanged.
- R4: A `kick` zeroes the count and leaves the settings unchanged, so kicking more often than the period prevents any time-out.
- R5: In reset-only mode (bit 4 = 1, bit 5 = 0), a time-out produces a `rst_pulse` exactly one clock long and does not set the flag.
- R6: In interrupt-only mode (bit 4 = 0, bit 5 = 1), a time-out sets the flag and drives `irq` high, and never pulses the reset. The flag stays set until a write with bit 7 = 1 clears it.
- R7: With both enables set, the first time-out sets the flag, clears the interrupt enable in hardware and does not reset. The next time-out then produces the reset pulse.
- R8: With both enables clear, the count is held and neither `irq` nor `rst_pulse` ever asserts.
- R9: A write with bits 6 and 4 both set opens a window that reads back on bit 6 for exactly `WIN` clocks. A write with bit 6 set but bit 4 clear opens no window.
- R10: Outside the window a write ignores the period code and cannot clear the reset enable, but it can set the reset enable and can write the interrupt enable either way.
- R11: A write inside the window loads the period code and both enables as written, and it closes the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_tick | input | 1 | One-clock enable per slow-oscillator period |
| kick | input | 1 | Clears the time-out count |
| cfg_we | input | 1 | Settings write strobe |
| cfg_wdata | input | 8 | Settings write word |
| cfg_rdata | output | 8 | Live settings, window state and flag |
| irq | output | 1 | Interrupt request (the sticky flag) |
| rst_pulse | output | 1 | One-clock system reset request |

## Verification
On every cycle, the assertions check the following. A reset pulse is one clock long and appears only in reset-only mode. Nothing happens while both enables are off. The period code and the clearing of the reset enable change only while the window is open. The window never stays open longer than `WIN` clocks. A hardware drop of the interrupt enable always comes with a raised flag. The exact period count for each code is shown only by the bench scenarios, and so is the clamp of large codes. The same holds for counting only on ticks, for kicks holding off a time-out, for the two-stage interrupt-then-reset order, and for the window accepting a write on its last clock but not one clock later.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int TSEL_W = 4;
  localparam int CFG_W  = 8;

  // Write word: {flag_clr, unlock, irq_en, rst_en, tsel}
  typedef struct packed {
    logic              flag_clr;
    logic              unlock;
    logic              irq_en;
    logic              rst_en;
    logic [TSEL_W-1:0] tsel;
  } cfg_wr_t;

  // Operating mode as {rst_en, irq_en}
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_IRQ  = 2'b01,
    MODE_RST  = 2'b10,
    MODE_BOTH = 2'b11
  } mode_e;

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int BASE    = 2048,
  parameter int MAX_SEL = 9,
  localparam int TW     = wdog_pkg::TSEL_W,
  localparam int CW     = $clog2(BASE) + MAX_SEL + 1,
  localparam int SW     = (MAX_SEL < 1) ? 1 : $clog2(MAX_SEL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          kick,
  input  logic [TW-1:0] tsel,
  output logic          expire
);

  logic [CW-1:0] lim_tab [MAX_SEL+1];
  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic [SW-1:0] sel_eff;
  logic          at_end;

  // Period table, one entry per legal code
  for (genvar g = 0; g <= MAX_SEL; g++) begin : g_lim
    assign lim_tab[g] = CW'(BASE) << g;
  end

  assign sel_eff = (tsel > TW'(MAX_SEL)) ? SW'(MAX_SEL) : tsel[SW-1:0];
  assign lim     = lim_tab[sel_eff];
  assign at_end  = (cnt_q >= lim - 1'b1);
  assign expire  = run && tick && !kick && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || kick)  cnt_d = '0;
    else if (tick)     cnt_d = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wdog_cfg_guard.sv
module wdog_cfg_guard #(
  parameter int WIN     = 4,
  localparam int TW     = wdog_pkg::TSEL_W,
  localparam int WW     = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [TW-1:0] wr_tsel,
  input  logic          wr_rst_en,
  input  logic          wr_irq_en,
  input  logic          wr_unlock,
  input  logic          hw_irq_clr,
  output logic [TW-1:0] tsel,
  output logic          rst_en,
  output logic          irq_en,
  output logic          win_open
);

  logic [TW-1:0] tsel_q, tsel_d;
  logic          rst_en_q, rst_en_d;
  logic          irq_en_q, irq_en_d;
  logic [WW-1:0] win_q, win_d;

  assign win_open = (win_q != '0);

  always_comb begin
    tsel_d   = tsel_q;
    rst_en_d = rst_en_q;
    irq_en_d = irq_en_q;
    win_d    = win_open ? win_q - 1'b1 : '0;
    if (we) begin
      if (win_open) begin
        tsel_d   = wr_tsel;
        rst_en_d = wr_rst_en;
        irq_en_d = wr_irq_en;
        win_d    = '0;
      end else begin
        irq_en_d = wr_irq_en;
        if (wr_rst_en)              rst_en_d = 1'b1;
        if (wr_unlock && wr_rst_en) win_d    = WW'(WIN);
      end
    end else if (hw_irq_clr) begin
      irq_en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsel_q   <= '0;
      rst_en_q <= 1'b0;
      irq_en_q <= 1'b0;
      win_q    <= '0;
    end else begin
      tsel_q   <= tsel_d;
      rst_en_q <= rst_en_d;
      irq_en_q <= irq_en_d;
      win_q    <= win_d;
    end
  end

  assign tsel   = tsel_q;
  assign rst_en = rst_en_q;
  assign irq_en = irq_en_q;

endmodule

// File: rtl/wdog_event.sv
module wdog_event
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic rst_en,
  input  logic irq_en,
  input  logic we,
  input  logic flag_clr,
  output logic flag,
  output logic pulse,
  output logic hw_irq_clr
);

  mode_e mode;
  logic  flag_q, flag_d;
  logic  pulse_q, pulse_d;

  assign mode = mode_e'({rst_en, irq_en});

  always_comb begin
    flag_d     = flag_q;
    pulse_d    = 1'b0;
    hw_irq_clr = 1'b0;
    if (we && flag_clr) flag_d = 1'b0;
    if (expire) begin
      unique case (mode)
        MODE_IRQ:  flag_d = 1'b1;
        MODE_RST:  pulse_d = 1'b1;
        MODE_BOTH: begin
          flag_d     = 1'b1;
          hw_irq_clr = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
    end
  end

  assign flag  = flag_q;
  assign pulse = pulse_q;

endmodule

// File: rtl/watchdog_ctrl.sv
module watchdog_ctrl
  import wdog_pkg::*;
#(
  parameter int BASE    = 2048,
  parameter int MAX_SEL = 9,
  parameter int WIN     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_tick,
  input  logic             kick,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             irq,
  output logic             rst_pulse
);

  cfg_wr_t            wr;
  logic               rst_n_s;
  logic [TSEL_W-1:0]  tsel;
  logic               rst_en, irq_en, win_open;
  logic               expire, hw_irq_clr, flag;

  assign wr = cfg_wr_t'(cfg_wdata);

  wdog_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  wdog_cfg_guard #(.WIN(WIN)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .we         (cfg_we),
    .wr_tsel    (wr.tsel),
    .wr_rst_en  (wr.rst_en),
    .wr_irq_en  (wr.irq_en),
    .wr_unlock  (wr.unlock),
    .hw_irq_clr (hw_irq_clr),
    .tsel       (tsel),
    .rst_en     (rst_en),
    .irq_en     (irq_en),
    .win_open   (win_open)
  );

  wdog_prescale #(.BASE(BASE), .MAX_SEL(MAX_SEL)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run    (rst_en | irq_en),
    .tick   (osc_tick),
    .kick   (kick),
    .tsel   (tsel),
    .expire (expire)
  );

  wdog_event u_evt (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .expire     (expire),
    .rst_en     (rst_en),
    .irq_en     (irq_en),
    .we         (cfg_we),
    .flag_clr   (wr.flag_clr),
    .flag       (flag),
    .pulse      (rst_pulse),
    .hw_irq_clr (hw_irq_clr)
  );

  assign irq       = flag;
  assign cfg_rdata = {flag, win_open, irq_en, rst_en, tsel};

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int WIN = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [7:0] cfg_rdata,
  input logic       irq,
  input logic       rst_pulse
);

  logic [31:0] open_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            open_run <= '0;
    else if (cfg_rdata[6]) open_run <= open_run + 1'b1;
    else                   open_run <= '0;
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rst_pulse |=> !rst_pulse); // R5
  AST_PULSE_RST_ONLY: assert property (@(posedge clk) disable iff (!rst_n) rst_pulse |-> ($past(cfg_rdata[4]) && !$past(cfg_rdata[5]))); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!$past(cfg_rdata[4]) && !$past(cfg_rdata[5])) |-> (!rst_pulse && !$rose(irq))); // R8
  AST_WIN_LEN: assert property (@(posedge clk) disable iff (!rst_n) open_run <= 32'(WIN)); // R9
  AST_TSEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) (cfg_rdata[3:0] != $past(cfg_rdata[3:0])) |-> $past(cfg_rdata[6])); // R10
  AST_RST_EN_GUARD: assert property (@(posedge clk) disable iff (!rst_n) $fell(cfg_rdata[4]) |-> $past(cfg_rdata[6])); // R10
  AST_HW_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n) ($fell(cfg_rdata[5]) && !$past(cfg_we)) |-> irq); // R7

endmodule

bind watchdog_ctrl wdog_chk #(.WIN(WIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_rdata (cfg_rdata),
  .irq       (irq),
  .rst_pulse (rst_pulse)
);

// File: tb/watchdog_ctrl_tb_top.sv
`timescale 1ns/1ps
module watchdog_ctrl_tb_top;

  localparam int BASE    = 4;
  localparam int MAX_SEL = 9;
  localparam int WIN     = 4;

  logic       clk;
  logic       rst_n;
  logic       osc_tick;
  logic       kick;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       irq;
  logic       rst_pulse;

  int checks;
  int failures;
  bit done;

  watchdog_ctrl #(.BASE(BASE), .MAX_SEL(MAX_SEL), .WIN(WIN)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .kick      (kick),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .irq       (irq),
    .rst_pulse (rst_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input bit fclr, input bit unl, input bit ie,
                                    input bit re, input int ts);
    return {fclr, unl, ie, re, 4'(ts)};
  endfunction

  function automatic int period(input int code);
    int c = (code > MAX_SEL) ? MAX_SEL : code;
    return BASE << c;
  endfunction

  // Called at a negedge; returns at the next negedge with the write taken.
  task automatic wr(input logic [7:0] d);
    cfg_we    = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic set_cfg(input int ts, input bit re, input bit ie);
    wr(mk(0, 1, 0, 1, 0));
    wr(mk(1, 0, ie, re, ts));
  endtask

  // Kick, then apply up to cap ticks (one every div clocks) and record
  // the tick count at which the first pulse and the flag show.
  task automatic measure(input int div, input int cap, output int t_pulse,
                         output int t_flag, output int n_pulse);
    int ticks = 0;
    int phase = 0;
    int extra = 0;
    t_pulse = -1; t_flag = -1; n_pulse = 0;
    osc_tick = 1'b0;
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    while (extra < 3) begin
      if (ticks < cap) begin
        phase++;
        osc_tick = ((phase % div) == 0);
        if (osc_tick) ticks++;
      end else begin
        osc_tick = 1'b0;
        extra++;
      end
      @(negedge clk);
      if (rst_pulse) begin
        n_pulse++;
        if (t_pulse < 0) t_pulse = ticks;
      end
      if (irq && t_flag < 0) t_flag = ticks;
    end
    osc_tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int tp, tf, np, n;
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; osc_tick = 1'b0; kick = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 rdata", int'(cfg_rdata), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 pulse", int'(rst_pulse), 0);

    // R10 writes outside the window
    wr(mk(0, 0, 0, 0, 5));
    check("R10 tsel ignored", int'(cfg_rdata[3:0]), 0);
    wr(mk(0, 0, 0, 1, 0));
    check("R10 rst_en set", int'(cfg_rdata[4]), 1);
    wr(mk(0, 0, 0, 0, 0));
    check("R10 rst_en clear ignored", int'(cfg_rdata[4]), 1);
    wr(mk(0, 0, 1, 1, 0));
    check("R10 irq_en set", int'(cfg_rdata[5]), 1);
    wr(mk(0, 0, 0, 1, 0));
    check("R10 irq_en clear", int'(cfg_rdata[5]), 0);

    // R9 window opening and length
    wr(mk(0, 1, 0, 0, 0));
    check("R9 unlock without rst bit", int'(cfg_rdata[6]), 0);
    wr(mk(0, 1, 0, 1, 0));
    n = 0;
    for (int i = 0; i < WIN + 2; i++) begin
      if (cfg_rdata[6]) n++;
      @(negedge clk);
    end
    check("R9 window length", n, WIN);
    wr(mk(0, 0, 0, 1, 7));
    check("R9 late write ignored", int'(cfg_rdata[3:0]), 0);

    // R11 write on the last window clock, then closing
    wr(mk(0, 1, 0, 1, 0));
    repeat (WIN - 1) @(negedge clk);
    wr(mk(0, 0, 0, 1, 7));
    check("R11 tsel loaded", int'(cfg_rdata[3:0]), 7);
    check("R11 window closed", int'(cfg_rdata[6]), 0);
    wr(mk(0, 1, 0, 1, 0));
    repeat (WIN) @(negedge clk);
    wr(mk(0, 0, 0, 1, 2));
    check("R9 one clock past window", int'(cfg_rdata[3:0]), 7);
    wr(mk(0, 1, 0, 1, 0));
    wr(mk(0, 0, 1, 0, 3));
    check("R11 rst_en cleared", int'(cfg_rdata[4]), 0);
    check("R11 irq_en", int'(cfg_rdata[5]), 1);
    check("R11 tsel", int'(cfg_rdata[3:0]), 3);

    // R2 / R3 / R5 period sweep in reset-only mode
    for (int t = 0; t < 16; t++) begin
      if (t > MAX_SEL && t != 10 && t != 12 && t != 15) continue;
      set_cfg(t, 1, 0);
      check("R3 code readback", int'(cfg_rdata[3:0]), t);
      measure(1, period(t), tp, tf, np);
      if (t > MAX_SEL) check("R3 clamped period", tp, period(MAX_SEL));
      else             check("R2 period", tp, period(t));
      check("R5 single one-clock pulse", np, 1);
      check("R5 no flag", tf, -1);
    end
    set_cfg(2, 1, 0);
    measure(3, period(2), tp, tf, np);
    check("R2 counts ticks only", tp, period(2));

    // R6 interrupt-only mode
    set_cfg(2, 0, 1);
    measure(1, 2 * period(2), tp, tf, np);
    check("R6 flag time", tf, period(2));
    check("R6 no pulse", np, 0);
    repeat (5) @(negedge clk);
    check("R6 flag sticky", int'(irq), 1);
    check("R6 irq_en kept", int'(cfg_rdata[5]), 1);
    wr(mk(1, 0, 1, 0, 0));
    check("R6 flag cleared", int'(irq), 0);

    // R7 interrupt then reset
    set_cfg(1, 1, 1);
    measure(1, 2 * period(1), tp, tf, np);
    check("R7 flag first", tf, period(1));
    check("R7 pulse second", tp, 2 * period(1));
    check("R7 one pulse", np, 1);
    check("R7 irq_en dropped", int'(cfg_rdata[5]), 0);

    // R8 all off
    set_cfg(0, 0, 0);
    measure(1, 64, tp, tf, np);
    check("R8 no pulse", np, 0);
    check("R8 no flag", tf, -1);

    // R4 kicks hold off the time-out
    set_cfg(0, 1, 0);
    n = 0;
    osc_tick = 1'b1;
    for (int i = 0; i < 30; i++) begin
      kick = ((i % 3) == 0);
      @(negedge clk);
      if (rst_pulse) n++;
    end
    osc_tick = 1'b0; kick = 1'b0;
    check("R4 no time-out under kicks", n, 0);
    check("R4 settings kept", int'(cfg_rdata[4:0]), 5'b10000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule